// File: doc/BRIEF.md
# Sliding-Window Pulse Burst Detector

This block watches a single-bit input on which each pulse lasts one clock cycle. It raises a one-cycle flag whenever the newest pulse, together with the pulses just before it, makes up a burst: `THRESH` pulses that all fall inside `WINDOW` consecutive cycles. The window has no fixed frame boundaries. Each arriving pulse is judged against the `THRESH-1` pulses that came before it, so the window slides one pulse at a time. Once a burst has been seen, the next pulse is judged against a group that starts at the second pulse of the earlier burst.

The block keeps the arrival ages of the last `THRESH-1` pulses. Each age counts up every cycle and stops once it reaches `WINDOW`, and a stopped age reads as expired. Defaults are `THRESH = 10` and `WINDOW = 100`. Elaboration rejects `THRESH < 2` and `WINDOW < THRESH`. Reset is synchronous and active high.

Top module: `burst_window_detector`

## Requirements
- R1: For a pulse on `pulse_in` in cycle t, `burst_det` is 1 in cycle t+1 exactly when at least `THRESH` pulses, counting the one at t, arrived in cycles t-WINDOW+1 through t. Otherwise it is 0.
- R2: While `rst` is 1, pulses are ignored, and `burst_det` is 0 in the cycle after any cycle with `rst` high. Pulses seen before reset never count toward a later burst.
- R3: `burst_det` is never 1 unless `pulse_in` was 1 in the cycle before.
- R4: Ten pulses whose first and last are 99 cycles apart are detected on the last pulse. If the first and last are 100 cycles apart, there is no detection, because the oldest pulse has left the window.
- R5: After a detection, every further pulse is judged again against the nine pulses before it. A detection repeats while that group still fits, and stops once it no longer fits.
- R6: A pulse that does not complete a burst does not stop later pulses from forming one.
- R7: Pulses on back-to-back cycles each count. `THRESH` consecutive pulses give a detection after the last of them, and a continuing run gives a detection in every following cycle.
- R8: After reset, no detection occurs until at least `THRESH` pulses have arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Pulse stream, one cycle per pulse |
| burst_det | output | 1 | High for one cycle after a pulse that completes a burst |

## Verification
Two things can land in the same cycle: a pulse that completes a burst, and the oldest pulse of its group leaving the window. The bench provokes this by spacing ten pulses so that the first and last are exactly 99 cycles apart, and then exactly 100 cycles apart. Only the first spacing may be flagged. A behavioural model keeps a queue of pulse times and judges every cycle, including these edge cases, a reset arriving in the middle of a burst, and a long pseudo-random stream.

// File: rtl/burst_window_detector.sv
module burst_window_detector #(
  parameter int THRESH = 10,
  parameter int WINDOW = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic burst_det
);
  localparam int DEPTH = THRESH - 1;
  localparam int AW = $clog2(WINDOW + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(WINDOW);

  if (THRESH < 2 || WINDOW < THRESH) begin : g_bad_params
    $error("burst_window_detector: need THRESH >= 2 and WINDOW >= THRESH");
  end

  logic [DEPTH-1:0][AW-1:0] age_q;
  logic [DEPTH-1:0][AW-1:0] age_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return (a == AGE_MAX) ? AGE_MAX : a + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      assign age_d[i] = pulse_in ? AW'(1) : bump(age_q[i]);
    end else begin : g_tail
      assign age_d[i] = pulse_in ? bump(age_q[i-1]) : bump(age_q[i]);
    end
  end

  wire hit = pulse_in && (age_q[DEPTH-1] != AGE_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= AGE_MAX;
      burst_det <= 1'b0;
    end else begin
      age_q     <= age_d;
      burst_det <= hit;
    end
  end
endmodule

// File: rtl/burst_window_checker.sv
module burst_window_checker #(
  parameter int THRESH = 10,
  parameter int WINDOW = 100
) (
  input logic clk,
  input logic rst,
  input logic pulse_in,
  input logic burst_det,
  input logic [$clog2(WINDOW+1)-1:0] oldest_age
);
  localparam int CW = $clog2(THRESH + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (pulse_in && seen != CW'(THRESH)) seen <= seen + 1'b1;
  end

  AST_DET_FOLLOWS_PULSE: assert property (@(posedge clk) disable iff (rst)
    burst_det |-> $past(pulse_in)); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !burst_det); // R2
  AST_NO_EARLY_DET: assert property (@(posedge clk) disable iff (rst)
    burst_det |-> (int'(seen) >= THRESH)); // R8
  AST_AGE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (!pulse_in && int'(oldest_age) < WINDOW) |=> int'(oldest_age) == int'($past(oldest_age)) + 1); // R4
  AST_EXPIRED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!pulse_in && int'(oldest_age) == WINDOW) |=> int'(oldest_age) == WINDOW); // R4
  AST_EXPIRED_NO_DET: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && int'(oldest_age) == WINDOW) |=> !burst_det); // R4
endmodule

bind burst_window_detector burst_window_checker #(.THRESH(THRESH), .WINDOW(WINDOW)) u_chk (
  .clk(clk),
  .rst(rst),
  .pulse_in(pulse_in),
  .burst_det(burst_det),
  .oldest_age(age_q[THRESH-2])
);

// File: tb/tb_burst_window_detector.sv
module tb_burst_window_detector;
  localparam int THRESH = 10;
  localparam int WINDOW = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;
  logic burst_det;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  int q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  burst_window_detector #(.THRESH(THRESH), .WINDOW(WINDOW)) dut (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .burst_det(burst_det)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: burst_det=%b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic p, input string tag);
    logic exp;
    pulse_in = p;
    if (rst) begin
      q.delete();
      exp = 1'b0;
    end else begin
      if (p) begin
        q.push_back(cyc);
        if (q.size() > THRESH) void'(q.pop_front());
      end
      exp = p && (q.size() == THRESH) && (cyc - q[0] <= WINDOW - 1);
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check(burst_det, exp, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    idle(3, "R2 reset");
    rst = 1'b0;
    idle(2, "R2 after reset");

    // R7: back-to-back run, then continuing stream
    for (int i = 0; i < THRESH + 5; i++) step(1'b1, "R7 consecutive");
    idle(WINDOW + 2, "R3 quiet");

    // R4: span 99 detects
    for (int k = 0; k < THRESH; k++) begin
      step(1'b1, "R4 span 99");
      if (k < THRESH - 1) idle(10, "R4 span 99");
    end
    idle(WINDOW + 2, "R3 quiet");

    // R4: span 100 does not
    for (int k = 0; k < THRESH; k++) begin
      step(1'b1, "R4 span 100");
      if (k < THRESH - 1) idle(k == 0 ? 11 : 10, "R4 span 100");
    end
    idle(WINDOW + 2, "R3 quiet");

    // R5: sliding re-anchor, then a gap breaks it
    for (int k = 0; k < THRESH + 2; k++) begin
      step(1'b1, "R5 slide");
      idle(9, "R5 slide");
    end
    idle(30, "R5 slide");
    step(1'b1, "R5 slide broken");
    idle(WINDOW + 2, "R3 quiet");

    // R6: lone failed start, later burst still found
    step(1'b1, "R6 lone");
    idle(95, "R6 lone");
    for (int k = 0; k < THRESH; k++) begin
      step(1'b1, "R6 later burst");
      idle(4, "R6 later burst");
    end
    idle(WINDOW + 2, "R3 quiet");

    // R2 / R8: history wiped by reset mid-burst
    for (int k = 0; k < THRESH - 1; k++) step(1'b1, "R8 pre reset");
    rst = 1'b1;
    step(1'b1, "R2 pulse in reset");
    idle(1, "R2 reset");
    rst = 1'b0;
    for (int k = 0; k < THRESH - 1; k++) step(1'b1, "R8 fresh pulses");
    step(1'b1, "R8 tenth fresh");
    idle(WINDOW + 2, "R3 quiet");

    // R1: pseudo-random stream
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0] == 3'b000, "R1 random");
    end
    idle(5, "R3 quiet");
    finish_run();
  end
endmodule